// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner folds a wide bank of level-sensitive interrupt lines into one request per group of eight, for a downstream interrupt controller. Every source has its own enable bit. A group request is high while at least one enabled source in the group is high. With the default parameters there are 64 groups, so 512 source lines and 64 request outputs. Source number n belongs to group n/8, at bit n%8 inside that group.

Software reaches the block through a 32-bit, single-cycle read/write port with a registered read-data output. Registers come in 16-byte sets, and each set covers four consecutive groups, one byte lane per group. A set holds a write-one-to-set enable register, a write-one-to-clear enable register, a raw status register and an enabled-status register. Above the sets are two summary words that mirror the group requests.

A parameter turns an instance into a reduced variant. In that variant, sources in groups at or above a configured limit are ignored.

Top module: `intr_combiner`

## Requirements
- R1: Group g uses source bits 8g..8g+7. Its request `grp_irq[g]` is high exactly when, for some bit, the source line was high at the previous clock edge and the matching enable bit is set. When no source is high, every request is low.
- R2: A write to offset 16*s+0x0 sets enable bits. For each lane k in 0..3, each 1 in data bits [8k+7:8k] sets the matching enable bit of group 4s+k. Bits that are 0 leave their enable bit unchanged.
- R3: A write to offset 16*s+0x4 clears enable bits. Each 1 in the same lane layout clears the matching enable bit. Bits that are 0 leave their enable bit unchanged.
- R4: A read of offset 16*s+0x8 returns the raw source status of groups 4s..4s+3, with group 4s in bits [7:0] and higher groups in higher bytes.
- R5: A read of offset 16*s+0xC returns the enable bits ANDed with the raw status, in the same byte packing as R4.
- R6: A read of offset 16*s+0x0 or 16*s+0x4 returns the current enable bits of the four groups, in the same byte packing as R4. The offsets listed in R11 are the exception.
- R7: A read of offset 0x100 returns requests 0..31, with group g in bit g. A read of offset 0x104 returns requests 32..63, with group 32+j in bit j.
- R8: A write to offset 16*s+0x8, to offset 16*s+0xC, to offset 0x100 or above, or anywhere outside the window changes no state. Such a write pulses `bus_err` in the cycle after the access. A legal access leaves `bus_err` low.
- R9: A read at offset 0x108 or above returns zero and pulses `bus_err`.
- R10: After reset, all enable bits, source status, requests, `bus_rdata` and `bus_err` are zero.
- R11: Reads of offsets 0xC0, 0xC4, 0xD0 and 0xD4 return a word that resets to 0x01010101. After any write to one of these offsets, that offset reads back the last value written to it. Such a write still acts on the enable bits as R2 and R3 describe.
- R12: With EXT_MODE=1, source lines of groups at or above EXT_MAX_GRP have no effect. Those requests stay low, and their raw status reads zero.
- R13: The requests and the summary words change exactly one clock after the source change or enable write that causes the change. Read data and `bus_err` appear one clock after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_GRP*8 | Level-sensitive source lines |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| bus_err | output | 1 | One-cycle pulse for an illegal access |
| grp_irq | output | NUM_GRP | Per-group request outputs |

## Verification
The hardest case to reach is a group with several pending sources while its enable bits go up and down in overlapping patterns. Only then does a single clear leave the request high, or a single set raise it without a source edge.

Random source words ANDed together keep the pending bits sparse. Random set and clear writes land on the same few registers, so enable patterns build up on top of each other. Every operation compares the requests against a model kept in the bench. The reduced instance shares the stimulus, so sources above its limit are exercised continuously.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int LANE_W = 8;
  localparam int LANES = 4;
  localparam int NUM_SHD = 4;
  localparam logic [31:0] SHD_RST = 32'h0101_0101;

  typedef enum logic [1:0] {
    RG_EN_SET = 2'd0,
    RG_EN_CLR = 2'd1,
    RG_RAW    = 2'd2,
    RG_MSK    = 2'd3
  } reg_sel_e;

  function automatic int shd_ofs(input int idx);
    case (idx)
      0: return 'hC0;
      1: return 'hC4;
      2: return 'hD0;
      default: return 'hD4;
    endcase
  endfunction
endpackage

// File: rtl/cmb_group_bank.sv
module cmb_group_bank
  import cmb_pkg::*;
#(
  parameter int NUM_GRP = 64,
  parameter bit EXT_MODE = 1'b0,
  parameter int EXT_MAX_GRP = 16,
  parameter int SET_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GRP*LANE_W-1:0]   src_in,
  input  logic                        wr_set,
  input  logic                        wr_clr,
  input  logic [SET_W-1:0]            wr_set_idx,
  input  logic [31:0]                 wr_data,
  output logic [NUM_GRP*LANE_W-1:0]   mask_flat,
  output logic [NUM_GRP*LANE_W-1:0]   pend_flat,
  output logic [NUM_GRP-1:0]          grp_irq
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int SET = g / LANES;
    localparam int LANE = g % LANES;
    localparam bit LIVE = !EXT_MODE || (g < EXT_MAX_GRP);

    logic [LANE_W-1:0] m_q, p_q, m_d, p_d, wbyte;
    logic hit, irq_q;

    assign hit = (wr_set_idx == SET_W'(SET));
    assign wbyte = wr_data[LANE*LANE_W +: LANE_W];

    always_comb begin
      m_d = m_q;
      if (hit && wr_set) m_d = m_q | wbyte;
      else if (hit && wr_clr) m_d = m_q & ~wbyte;
      p_d = LIVE ? src_in[g*LANE_W +: LANE_W] : p_q;
    end

    // request computed from next state so it lands one edge after its cause
    always_ff @(posedge clk) begin
      if (rst) begin
        m_q <= '0;
        p_q <= '0;
        irq_q <= 1'b0;
      end else begin
        m_q <= m_d;
        p_q <= p_d;
        irq_q <= |(m_d & p_d);
      end
    end

    assign mask_flat[g*LANE_W +: LANE_W] = m_q;
    assign pend_flat[g*LANE_W +: LANE_W] = p_q;
    assign grp_irq[g] = irq_q;
  end
endmodule

// File: rtl/cmb_reg_port.sv
module cmb_reg_port
  import cmb_pkg::*;
#(
  parameter int NUM_GRP = 64,
  parameter int ADDR_W = 9,
  parameter int SET_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic [NUM_GRP*LANE_W-1:0]   mask_flat,
  input  logic [NUM_GRP*LANE_W-1:0]   pend_flat,
  input  logic [NUM_GRP-1:0]          grp_irq,
  output logic                        wr_set,
  output logic                        wr_clr,
  output logic [SET_W-1:0]            wr_set_idx,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_err
);
  localparam int NUM_SET = NUM_GRP / LANES;
  localparam int SUM_BASE = NUM_SET * 16;
  localparam int SUM_WORDS = (NUM_GRP + 31) / 32;
  localparam int WIN_END = SUM_BASE + 4 * SUM_WORDS;
  localparam int WA_W = ADDR_W - 2;
  localparam bit SHD_EN = SUM_BASE > 'hD4;

  logic in_sets, in_sum, wr_ok, illegal;
  logic [SET_W-1:0] set_idx;
  reg_sel_e rsel;
  logic [WA_W-1:0] wa;
  logic [SUM_WORDS*32-1:0] sum_vec;
  logic [31:0] rd_val;
  logic [NUM_SHD-1:0] shd_hit;
  logic [31:0] shd_q [NUM_SHD];

  assign wa = bus_addr[ADDR_W-1:2];
  assign in_sets = bus_addr < ADDR_W'(SUM_BASE);
  assign in_sum = !in_sets && (bus_addr < ADDR_W'(WIN_END));
  assign set_idx = bus_addr[SET_W+3:4];
  assign rsel = reg_sel_e'(bus_addr[3:2]);
  assign wr_ok = in_sets && (rsel == RG_EN_SET || rsel == RG_EN_CLR);
  assign illegal = bus_sel && (bus_wr ? !wr_ok : !(in_sets || in_sum));
  assign sum_vec = (SUM_WORDS*32)'(grp_irq);

  assign wr_set = bus_sel && bus_wr && in_sets && (rsel == RG_EN_SET);
  assign wr_clr = bus_sel && bus_wr && in_sets && (rsel == RG_EN_CLR);
  assign wr_set_idx = set_idx;

  for (genvar s = 0; s < NUM_SHD; s++) begin : g_shd
    assign shd_hit[s] = SHD_EN && (wa == WA_W'(shd_ofs(s) / 4));
    always_ff @(posedge clk) begin
      if (rst) shd_q[s] <= SHD_RST;
      else if (bus_sel && bus_wr && shd_hit[s]) shd_q[s] <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_sets) begin
      for (int k = 0; k < LANES; k++) begin
        logic [SET_W+1:0] gi;
        logic [LANE_W-1:0] mb, pb;
        gi = {set_idx, 2'(k)};
        mb = mask_flat[{gi, 3'b000} +: LANE_W];
        pb = pend_flat[{gi, 3'b000} +: LANE_W];
        case (rsel)
          RG_RAW:  rd_val[k*LANE_W +: LANE_W] = pb;
          RG_MSK:  rd_val[k*LANE_W +: LANE_W] = mb & pb;
          default: rd_val[k*LANE_W +: LANE_W] = mb;
        endcase
      end
      for (int s = 0; s < NUM_SHD; s++)
        if (shd_hit[s]) rd_val = shd_q[s];
    end else if (in_sum) begin
      for (int w = 0; w < SUM_WORDS; w++)
        if (wa == WA_W'(SUM_BASE / 4 + w)) rd_val = sum_vec[w*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err <= 1'b0;
    end else begin
      bus_err <= illegal;
      if (bus_sel && !bus_wr) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/intr_combiner.sv
module intr_combiner
  import cmb_pkg::*;
#(
  parameter int NUM_GRP = 64,
  parameter int ADDR_W = 9,
  parameter bit EXT_MODE = 1'b0,
  parameter int EXT_MAX_GRP = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GRP*8-1:0]        src_in,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_err,
  output logic [NUM_GRP-1:0]          grp_irq
);
  localparam int SET_W = $clog2(NUM_GRP / LANES);

  logic wr_set, wr_clr;
  logic [SET_W-1:0] wr_set_idx;
  logic [NUM_GRP*LANE_W-1:0] mask_flat, pend_flat;

  cmb_group_bank #(
    .NUM_GRP(NUM_GRP), .EXT_MODE(EXT_MODE),
    .EXT_MAX_GRP(EXT_MAX_GRP), .SET_W(SET_W)
  ) u_bank (
    .clk(clk), .rst(rst), .src_in(src_in),
    .wr_set(wr_set), .wr_clr(wr_clr), .wr_set_idx(wr_set_idx),
    .wr_data(bus_wdata), .mask_flat(mask_flat), .pend_flat(pend_flat),
    .grp_irq(grp_irq)
  );

  cmb_reg_port #(
    .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .SET_W(SET_W)
  ) u_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mask_flat(mask_flat), .pend_flat(pend_flat), .grp_irq(grp_irq),
    .wr_set(wr_set), .wr_clr(wr_clr), .wr_set_idx(wr_set_idx),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
  parameter int NUM_GRP = 64,
  parameter int ADDR_W = 9,
  parameter bit EXT_MODE = 1'b0,
  parameter int EXT_MAX_GRP = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_GRP*8-1:0] src_in,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic                 bus_err,
  input logic [NUM_GRP-1:0]   grp_irq
);
  localparam int SUM_BASE = NUM_GRP * 4;
  localparam int WIN_END = SUM_BASE + 4 * ((NUM_GRP + 31) / 32);

  logic en_wr, bad_wr, undef_rd;
  assign en_wr = bus_sel && bus_wr && (bus_addr < ADDR_W'(SUM_BASE)) && !bus_addr[3];
  assign bad_wr = bus_sel && bus_wr && !en_wr;
  assign undef_rd = bus_sel && !bus_wr && (bus_addr >= ADDR_W'(WIN_END));

  p_no_src_no_irq_r1: assert property (@(posedge clk) disable iff (rst)
    (src_in == '0) |=> (grp_irq == '0));

  p_irq_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!en_wr && (src_in == $past(src_in))) |=> $stable(grp_irq));

  p_bad_wr_err_r8: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> bus_err);

  p_legal_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel || en_wr || (!bus_wr && !undef_rd)) |=> !bus_err);

  p_undef_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    undef_rd |=> (bus_rdata == '0 && bus_err));

  if (NUM_GRP >= 32) begin : g_sum
    p_summary_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(SUM_BASE))
        |=> (bus_rdata == $past(grp_irq[31:0])));
  end

  if (EXT_MODE && EXT_MAX_GRP < NUM_GRP) begin : g_ext
    p_ext_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      grp_irq[NUM_GRP-1:EXT_MAX_GRP] == '0);
  end
endmodule

bind intr_combiner cmb_checker #(
  .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W),
  .EXT_MODE(EXT_MODE), .EXT_MAX_GRP(EXT_MAX_GRP)
) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .grp_irq(grp_irq)
);

// File: tb/intr_combiner_bench.sv
`timescale 1ns/1ps
module intr_combiner_bench;
  localparam int NG = 64;
  localparam int EXT_LIM = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NG*8-1:0] src = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_x;
  logic err, err_x;
  logic [NG-1:0] irq, irq_x;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_mask [NG];
  logic [31:0] m_shd [4];

  always #2 clk = ~clk;

  intr_combiner u_intr_combiner (
    .clk(clk), .rst(rst), .src_in(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_err(err), .grp_irq(irq));

  intr_combiner #(.EXT_MODE(1'b1), .EXT_MAX_GRP(EXT_LIM)) u_ext (
    .clk(clk), .rst(rst), .src_in(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_x),
    .bus_err(err_x), .grp_irq(irq_x));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_irq(input bit ext);
    logic [NG-1:0] r = '0;
    for (int g = 0; g < NG; g++)
      if (!ext || g < EXT_LIM) r[g] = |(m_mask[g] & src[g*8 +: 8]);
    return r;
  endfunction

  function automatic int shd_idx(input logic [8:0] a);
    case (a)
      9'h0C0: return 0;
      9'h0C4: return 1;
      9'h0D0: return 2;
      9'h0D4: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [32:0] exp_read(input logic [8:0] a, input bit ext);
    logic [31:0] d = '0;
    logic [NG-1:0] ir = exp_irq(ext);
    if (a < 9'h100) begin
      for (int k = 0; k < 4; k++) begin
        int g = a[7:4] * 4 + k;
        logic [7:0] p = (ext && g >= EXT_LIM) ? 8'h00 : src[g*8 +: 8];
        case (a[3:2])
          2'd2: d[k*8 +: 8] = p;
          2'd3: d[k*8 +: 8] = m_mask[g] & p;
          default: d[k*8 +: 8] = m_mask[g];
        endcase
      end
      if (shd_idx(a) >= 0) d = m_shd[shd_idx(a)];
      return {1'b0, d};
    end
    if (a == 9'h100) return {1'b0, ir[31:0]};
    if (a == 9'h104) return {1'b0, ir[63:32]};
    return {1'b1, 32'h0};
  endfunction

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    if (a < 9'h100 && !a[3]) begin
      for (int k = 0; k < 4; k++) begin
        int g = a[7:4] * 4 + k;
        if (!a[2]) m_mask[g] = m_mask[g] | d[k*8 +: 8];
        else m_mask[g] = m_mask[g] & ~d[k*8 +: 8];
      end
      if (shd_idx(a) >= 0) m_shd[shd_idx(a)] = d;
    end
  endtask

  task automatic bus_read(input logic [8:0] a);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic set_src(input logic [NG*8-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a);
    logic [32:0] e = exp_read(a, 1'b0);
    logic [32:0] ex = exp_read(a, 1'b1);
    bus_read(a);
    chk(tag, {err, rdata}, e);
    chk("R12 ext read", {err_x, rdata_x}, ex);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NG*8-1:0] v;
    void'($urandom(32'd20240611));
    for (int g = 0; g < NG; g++) m_mask[g] = 8'h00;
    for (int s = 0; s < 4; s++) m_shd[s] = 32'h0101_0101;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", irq, '0);
    chk("R10 rdata", rdata, '0);
    chk("R10 err", err, 0);
    rd_chk("R10 enable read", 9'h010);
    // R11 shadow reset values
    rd_chk("R11 reset 0xC0", 9'h0C0);
    rd_chk("R11 reset 0xD4", 9'h0D4);

    // R1 source with no enable gives no request
    v = '0; v[0] = 1'b1;
    set_src(v);
    chk("R1 masked off", irq, '0);
    // R2 enable set, R13 one-cycle latency
    bus_write(9'h000, 32'h0000_0001);
    chk("R2 enable set irq", irq, exp_irq(0));
    chk("R13 write latency", irq[0], 1);
    // R3 enable clear
    bus_write(9'h004, 32'h0000_0001);
    chk("R3 enable clear irq", irq[0], 0);

    // group 5 lane 1, source bit 7; group 40 lane 0
    bus_write(9'h010, 32'h0000_FF00);
    bus_write(9'h0A0, 32'h0000_0010);
    v = '0; v[5*8+7] = 1'b1; v[40*8+4] = 1'b1; v[41*8] = 1'b1;
    set_src(v);
    chk("R13 source latency", irq, exp_irq(0));
    chk("R1 group5", irq[5], 1);
    rd_chk("R4 raw read", 9'h018);
    rd_chk("R5 masked read", 9'h0AC);
    rd_chk("R6 enable read", 9'h010);
    rd_chk("R7 summary lo", 9'h100);
    rd_chk("R7 summary hi", 9'h104);
    chk("R7 group40", irq[40], 1);

    // R8 illegal writes
    bus_write(9'h018, 32'hFFFF_FFFF);
    chk("R8 err raw write", err, 1);
    bus_write(9'h01C, 32'hFFFF_FFFF);
    chk("R8 err masked write", err, 1);
    bus_write(9'h104, 32'hFFFF_FFFF);
    chk("R8 err summary write", err, 1);
    bus_write(9'h10C, 32'hFFFF_FFFF);
    chk("R8 err outside write", err, 1);
    chk("R8 irq unchanged", irq, exp_irq(0));
    rd_chk("R8 enable unchanged", 9'h010);
    bus_write(9'h014, 32'h0);
    chk("R8 legal write no err", err, 0);

    // R9 undefined reads
    rd_chk("R9 read 0x108", 9'h108);
    rd_chk("R9 read 0x1FC", 9'h1FC);

    // R11 shadow after write, enable still applied
    bus_write(9'h0C0, 32'h0000_0003);
    rd_chk("R11 shadow written", 9'h0C0);
    v[48*8+1] = 1'b1;
    set_src(v);
    chk("R11 enable applied", irq[48], 1);
    rd_chk("R11 masked status", 9'h0CC);

    // R12 sources above limit ignored in reduced instance
    bus_write(9'h0F0, 32'hFFFF_FFFF);
    v[60*8+2] = 1'b1;
    set_src(v);
    chk("R12 full instance", irq[60], 1);
    chk("R12 ext quiet", irq_x, exp_irq(1));
    rd_chk("R12 raw upper", 9'h0F8);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: begin
          for (int w = 0; w < NG / 4; w++)
            v[w*32 +: 32] = $urandom & $urandom & $urandom;
          set_src(v);
          chk("R1 random src", irq, exp_irq(0));
          chk("R12 random src", irq_x, exp_irq(1));
        end
        1: begin
          logic [8:0] a = {1'b0, 4'($urandom_range(0, 15)), 1'b0, 1'($urandom), 2'b00};
          bus_write(a, $urandom & $urandom);
          chk("R2/R3 random enable", irq, exp_irq(0));
          chk("R12 random enable", irq_x, exp_irq(1));
        end
        2: rd_chk("R6 random read", 9'($urandom_range(0, 'h10F) & 'h1FC));
        default: begin
          logic [8:0] a = {1'b0, 4'($urandom_range(0, 15)), 1'b1, 1'($urandom), 2'b00};
          if ($urandom_range(0, 3) == 0) a = 9'h100 + 9'($urandom_range(0, 63) * 4);
          bus_write(a, $urandom);
          chk("R8 random illegal err", err, 1);
          chk("R8 random illegal irq", irq, exp_irq(0));
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule